// File: doc/BRIEF.md
# Command Slot Issue Scheduler

This block is the dispatch core of one storage port. Software posts work by setting bits in a command-issue register, one bit per command slot. While the port engine is started, the scheduler takes the lowest-numbered posted slot and offers it to an execution unit over a valid/ready handshake. After the handoff it waits for a single response pulse. If the device is idle at that moment, the slot is retired at once. If the device is still busy or still requesting data, the slot number is held as a busy slot, and its bit is retired later, once the device goes quiet.

The block also holds the port control register. Its two running flags cannot be written by software: each follows its own enable bit. The first time the receive-running flag turns on after reset, the block sends out a single initial status event. A third register tracks active queued tags. Software sets tags by writing. Completed tags gather in a finished set. A read strobe on the active register retires every finished tag and empties that set.

Top module: `cs_slot_sched`

## Requirements
- R1: A write to the issue register (wr_sel = 0) ORs wr_data into the stored bits. Writing zeros never clears a bit.
- R2: No slot is offered while control bit 0 (start) is clear, even when issue bits are set.
- R3: The offered slot is always the lowest-numbered issued slot. After a slot retires, selection starts again from slot 0, so a lower slot issued in the meantime goes first.
- R4: No slot is offered while dev_busy or dev_drq is high.
- R5: A response arriving while dev_busy and dev_drq are both low clears the issue bit of the dispatched slot in that same clock edge.
- R6: A response arriving while dev_busy or dev_drq is high leaves the issue bit set and blocks further offers. The bit is cleared on the first edge where both signals are low.
- R7: While disp_valid is high and disp_ready is low, disp_valid stays high and disp_slot keeps its value.
- R8: A write to the control register (wr_sel = 1) ignores wr_data bits 15 and 14. Bit 15 (list running) becomes equal to bit 0 (start), and bit 14 (receive running) becomes equal to bit 4 (receive enable).
- R9: init_evt pulses for exactly one cycle, the first time bit 14 becomes set after reset. It never pulses again until the next reset.
- R10: A write to the active register (wr_sel = 2) ORs in tags. Each fin_set pulse adds tags to a hidden finished set. An act_rd strobe clears the finished tags from the active register and empties the set.
- R11: After reset the issue, active and control registers are zero, and disp_valid and init_evt are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Target register: 0 issue, 1 control, 2 active |
| wr_data | input | DW | Write data |
| act_rd | input | 1 | Read strobe of the active register (retires finished tags) |
| fin_set | input | NSLOT | Tags finished this cycle |
| dev_busy | input | 1 | Device busy status |
| dev_drq | input | 1 | Device data-request status |
| disp_valid | output | 1 | A slot is being offered |
| disp_slot | output | SW | Offered slot number |
| disp_ready | input | 1 | Execution unit accepts the offer |
| rsp_valid | input | 1 | Execution unit finished handling the accepted slot |
| issue_q | output | NSLOT | Command-issue register |
| active_q | output | NSLOT | Active-tag register |
| ctrl_q | output | DW | Port control register |
| init_evt | output | 1 | One-time initial status event |

## Verification
The assertions check several rules on every cycle. The offer is held stable until it is accepted. A new offer only starts after an idle-device, engine-started cycle. The offered slot is always issued and the lowest one set. Issue bits only drop on a response or on a quiet-device cycle. The running flags always match their enables, and the initial event fires at most once. The directed scenarios are needed to show the remaining behaviour: the OR-only write semantics, restarting from slot 0 after a retirement, the deferred retirement of a busy slot, and how the finished set is consumed by the read strobe.

// File: rtl/cs_pkg.sv
package cs_pkg;
   typedef enum logic [1:0] {
      SEL_ISSUE  = 2'd0,
      SEL_CTRL   = 2'd1,
      SEL_ACTIVE = 2'd2
   } reg_sel_e;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_OFFER = 2'd1,
      PH_WAIT  = 2'd2
   } phase_e;

   localparam int CTRL_START   = 0;
   localparam int CTRL_RXEN    = 4;
   localparam int CTRL_RXRUN   = 14;
   localparam int CTRL_LISTRUN = 15;
endpackage

// File: rtl/cs_prio_pick.sv
module cs_prio_pick #(
   parameter int N         = 32,
   parameter int W         = 5,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [N-1:0] req,
   output logic         found,
   output logic [W-1:0] idx
);
   if (LOW_FIRST) begin : g_low
      always_comb begin
         found = 1'b0;
         idx   = '0;
         for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
               found = 1'b1;
               idx   = W'(i);
            end
         end
      end
   end else begin : g_high
      always_comb begin
         found = 1'b0;
         idx   = '0;
         for (int i = 0; i < N; i++) begin
            if (req[i]) begin
               found = 1'b1;
               idx   = W'(i);
            end
         end
      end
   end
endmodule

// File: rtl/cs_ctrl_reg.sv
module cs_ctrl_reg
   import cs_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] ctrl_q,
   output logic          init_evt
);
   logic          init_done;
   logic [DW-1:0] ctrl_n;

   always_comb begin
      ctrl_n               = wdata;
      ctrl_n[CTRL_LISTRUN] = wdata[CTRL_START];
      ctrl_n[CTRL_RXRUN]   = wdata[CTRL_RXEN];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         init_done <= 1'b0;
         init_evt  <= 1'b0;
      end else begin
         init_evt <= 1'b0;
         if (wr) begin
            ctrl_q <= ctrl_n;
            if (ctrl_n[CTRL_RXRUN] && !init_done) begin
               init_evt  <= 1'b1;
               init_done <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/cs_tag_track.sv
module cs_tag_track #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [N-1:0] wdata,
   input  logic [N-1:0] fin_set,
   input  logic         rd,
   output logic [N-1:0] active_q
);
   logic [N-1:0] finished_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q   <= '0;
         finished_q <= '0;
      end else begin
         if (rd) begin
            active_q   <= (active_q & ~finished_q) | (wr ? wdata : '0);
            finished_q <= fin_set;
         end else begin
            active_q   <= active_q | (wr ? wdata : '0);
            finished_q <= finished_q | fin_set;
         end
      end
   end
endmodule

// File: rtl/cs_slot_sched.sv
module cs_slot_sched
   import cs_pkg::*;
#(
   parameter int NSLOT     = 32,
   parameter int DW        = 32,
   parameter bit LOW_FIRST = 1'b1,
   localparam int SW       = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [DW-1:0]    wr_data,
   input  logic             act_rd,
   input  logic [NSLOT-1:0] fin_set,
   input  logic             dev_busy,
   input  logic             dev_drq,
   output logic             disp_valid,
   output logic [SW-1:0]    disp_slot,
   input  logic             disp_ready,
   input  logic             rsp_valid,
   output logic [NSLOT-1:0] issue_q,
   output logic [NSLOT-1:0] active_q,
   output logic [DW-1:0]    ctrl_q,
   output logic             init_evt
);
   if (NSLOT < 2 || NSLOT > DW) begin : g_bad_nslot
      $error("cs_slot_sched: NSLOT must lie in 2..DW");
   end
   if (DW <= CTRL_LISTRUN) begin : g_bad_dw
      $error("cs_slot_sched: DW too narrow for control fields");
   end

   localparam logic [NSLOT-1:0] ONE = {{(NSLOT-1){1'b0}}, 1'b1};

   reg_sel_e         sel;
   phase_e           ph_q;
   logic [SW-1:0]    cur_q;
   logic             busy_vld_q;
   logic [SW-1:0]    busy_id_q;
   logic             pick_found;
   logic [SW-1:0]    pick_idx;
   logic             dev_quiet;
   logic             can_start;
   logic             rsp_fire;
   logic             retire;
   logic [NSLOT-1:0] clr_vec;
   logic [NSLOT-1:0] set_vec;

   assign sel       = reg_sel_e'(wr_sel);
   assign dev_quiet = !dev_busy && !dev_drq;

   cs_prio_pick #(.N(NSLOT), .W(SW), .LOW_FIRST(LOW_FIRST)) u_pick (
      .req   (issue_q),
      .found (pick_found),
      .idx   (pick_idx)
   );

   cs_ctrl_reg #(.DW(DW)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_en && sel == SEL_CTRL),
      .wdata    (wr_data),
      .ctrl_q   (ctrl_q),
      .init_evt (init_evt)
   );

   cs_tag_track #(.N(NSLOT)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (wr_en && sel == SEL_ACTIVE),
      .wdata    (wr_data[NSLOT-1:0]),
      .fin_set  (fin_set),
      .rd       (act_rd),
      .active_q (active_q)
   );

   assign can_start = (ph_q == PH_IDLE) && ctrl_q[CTRL_START] && pick_found
                      && dev_quiet && !busy_vld_q;
   assign rsp_fire  = (ph_q == PH_WAIT) && rsp_valid;
   assign retire    = busy_vld_q && dev_quiet;

   always_comb begin
      clr_vec = '0;
      if (rsp_fire && dev_quiet) clr_vec = ONE << cur_q;
      if (retire)                clr_vec = clr_vec | (ONE << busy_id_q);
      set_vec = (wr_en && sel == SEL_ISSUE) ? wr_data[NSLOT-1:0] : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         issue_q    <= '0;
         ph_q       <= PH_IDLE;
         cur_q      <= '0;
         busy_vld_q <= 1'b0;
         busy_id_q  <= '0;
      end else begin
         issue_q <= (issue_q & ~clr_vec) | set_vec;
         if (retire) busy_vld_q <= 1'b0;
         unique case (ph_q)
            PH_IDLE: if (can_start) begin
               cur_q <= pick_idx;
               ph_q  <= PH_OFFER;
            end
            PH_OFFER: if (disp_ready) ph_q <= PH_WAIT;
            PH_WAIT: if (rsp_valid) begin
               ph_q <= PH_IDLE;
               if (!dev_quiet) begin
                  busy_vld_q <= 1'b1;
                  busy_id_q  <= cur_q;
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign disp_valid = (ph_q == PH_OFFER);
   assign disp_slot  = cur_q;
endmodule

// File: rtl/cs_slot_sched_chk.sv
module cs_slot_sched_chk
   import cs_pkg::*;
#(
   parameter int NSLOT     = 32,
   parameter int DW        = 32,
   parameter bit LOW_FIRST = 1'b1,
   localparam int SW       = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             dev_busy,
   input logic             dev_drq,
   input logic             disp_valid,
   input logic [SW-1:0]    disp_slot,
   input logic             disp_ready,
   input logic             rsp_valid,
   input logic [NSLOT-1:0] issue_q,
   input logic [DW-1:0]    ctrl_q,
   input logic             init_evt
);
   localparam logic [NSLOT-1:0] ONE = {{(NSLOT-1){1'b0}}, 1'b1};

   logic [1:0]       evt_seen;
   logic [NSLOT-1:0] below_mask;

   assign below_mask = (ONE << disp_slot) - ONE;

   always_ff @(posedge clk) begin
      if (!rst_n) evt_seen <= '0;
      else if (init_evt && evt_seen != 2'd3) evt_seen <= evt_seen + 2'd1;
   end

   AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid && !disp_ready |=> disp_valid && $stable(disp_slot)); // R7

   AST_START_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disp_valid) |-> $past(ctrl_q[CTRL_START])); // R2

   AST_QUIET_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disp_valid) |-> $past(!dev_busy && !dev_drq)); // R4

   AST_SLOT_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> issue_q[disp_slot]); // R3

   AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disp_valid) |-> (!LOW_FIRST || ($past(issue_q) & below_mask) == '0)); // R3

   AST_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(issue_q) & ~issue_q) != '0) |->
         ($past(rsp_valid) || $past(!dev_busy && !dev_drq))); // R1

   AST_RUN_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[CTRL_LISTRUN] == ctrl_q[CTRL_START] &&
      ctrl_q[CTRL_RXRUN] == ctrl_q[CTRL_RXEN]); // R8

   AST_INIT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      init_evt |-> evt_seen == 2'd0); // R9
endmodule

bind cs_slot_sched cs_slot_sched_chk #(
   .NSLOT(NSLOT), .DW(DW), .LOW_FIRST(LOW_FIRST)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dev_busy   (dev_busy),
   .dev_drq    (dev_drq),
   .disp_valid (disp_valid),
   .disp_slot  (disp_slot),
   .disp_ready (disp_ready),
   .rsp_valid  (rsp_valid),
   .issue_q    (issue_q),
   .ctrl_q     (ctrl_q),
   .init_evt   (init_evt)
);

// File: tb/tb_cs_slot_sched.sv
module tb_cs_slot_sched;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic        act_rd = 1'b0;
   logic [31:0] fin_set = '0;
   logic        dev_busy = 1'b0;
   logic        dev_drq = 1'b0;
   logic        disp_valid;
   logic [4:0]  disp_slot;
   logic        disp_ready = 1'b0;
   logic        rsp_valid = 1'b0;
   logic [31:0] issue_q;
   logic [31:0] active_q;
   logic [31:0] ctrl_q;
   logic        init_evt;

   int n_chk = 0;
   int n_fail = 0;
   int init_cnt = 0;

   always #4 clk = ~clk;

   cs_slot_sched dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .act_rd(act_rd), .fin_set(fin_set), .dev_busy(dev_busy), .dev_drq(dev_drq),
      .disp_valid(disp_valid), .disp_slot(disp_slot), .disp_ready(disp_ready),
      .rsp_valid(rsp_valid), .issue_q(issue_q), .active_q(active_q),
      .ctrl_q(ctrl_q), .init_evt(init_evt)
   );

   always @(posedge clk) if (rst_n && init_evt) init_cnt++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Acts as the execution unit for one slot.
   task automatic serve(input int exp, input bit busy_rsp, input int hold);
      int t = 0;
      logic [4:0] s0;
      while (!disp_valid && t < 50) begin
         @(negedge clk);
         t++;
      end
      chk("R3 offered slot", {27'd0, disp_slot}, exp);
      s0 = disp_slot;
      for (int i = 0; i < hold; i++) begin
         @(negedge clk);
         chk("R7 valid held", {31'd0, disp_valid}, 32'd1);
         chk("R7 slot held", {27'd0, disp_slot}, {27'd0, s0});
      end
      disp_ready = 1'b1;
      @(negedge clk);
      disp_ready = 1'b0;
      rsp_valid = 1'b1;
      dev_busy = busy_rsp;
      @(negedge clk);
      rsp_valid = 1'b0;
      if (busy_rsp) chk("R6 bit kept while busy", {31'd0, issue_q[exp]}, 32'd1);
      else          chk("R5 bit cleared at response", {31'd0, issue_q[exp]}, 32'd0);
   endtask

   task automatic t_reset;
      chk("R11 issue", issue_q, 32'd0);
      chk("R11 active", active_q, 32'd0);
      chk("R11 ctrl", ctrl_q, 32'd0);
      chk("R11 disp_valid", {31'd0, disp_valid}, 32'd0);
      chk("R11 init_evt", {31'd0, init_evt}, 32'd0);
   endtask

   task automatic t_ctrl;
      wr(2'd1, 32'h0000_C000);
      chk("R8 running bits ignored", ctrl_q, 32'h0);
      idle(1);
      chk("R9 no event yet", init_cnt, 0);
      wr(2'd1, 32'h0000_0010);
      chk("R8 rx running follows enable", ctrl_q, 32'h0000_4010);
      idle(1);
      chk("R9 first event", init_cnt, 1);
      wr(2'd1, 32'h0);
      wr(2'd1, 32'h0000_0011);
      chk("R8 both running bits", ctrl_q, 32'h0000_C011);
      idle(2);
      chk("R9 single event only", init_cnt, 1);
   endtask

   task automatic t_start_gate;
      wr(2'd1, 32'h0000_0010);
      wr(2'd0, 32'h1);
      idle(5);
      chk("R2 no offer when stopped", {31'd0, disp_valid}, 32'd0);
      chk("R2 issue kept", issue_q, 32'h1);
      wr(2'd1, 32'h0000_0011);
      serve(0, 1'b0, 3);
      chk("R5 issue empty", issue_q, 32'h0);
   endtask

   task automatic t_or_and_block;
      dev_drq = 1'b1;
      wr(2'd0, 32'h3);
      wr(2'd0, 32'h4);
      chk("R1 or accumulate", issue_q, 32'h7);
      wr(2'd0, 32'h0);
      chk("R1 zero write keeps", issue_q, 32'h7);
      idle(4);
      chk("R4 drq blocks", {31'd0, disp_valid}, 32'd0);
      dev_drq = 1'b0;
      dev_busy = 1'b1;
      idle(4);
      chk("R4 busy blocks", {31'd0, disp_valid}, 32'd0);
      dev_busy = 1'b0;
      serve(0, 1'b0, 0);
      serve(1, 1'b0, 1);
      serve(2, 1'b0, 0);
      chk("R3 all retired", issue_q, 32'h0);
   endtask

   task automatic t_restart;
      wr(2'd0, 32'h8000_0024);
      serve(2, 1'b0, 0);
      dev_drq = 1'b1;
      wr(2'd0, 32'h1);
      dev_drq = 1'b0;
      serve(0, 1'b0, 0);
      serve(5, 1'b0, 0);
      serve(31, 1'b0, 0);
      chk("R3 restart drained", issue_q, 32'h0);
   endtask

   task automatic t_busy;
      wr(2'd0, 32'h9);
      serve(0, 1'b1, 0);
      idle(4);
      chk("R6 no offer while busy slot", {31'd0, disp_valid}, 32'd0);
      chk("R6 issue kept", issue_q, 32'h9);
      dev_busy = 1'b0;
      dev_drq = 1'b1;
      idle(2);
      chk("R6 drq keeps bit", issue_q, 32'h9);
      dev_drq = 1'b0;
      idle(1);
      chk("R6 deferred retire", issue_q, 32'h8);
      serve(3, 1'b0, 0);
      chk("R6 then drained", issue_q, 32'h0);
   endtask

   task automatic t_active;
      wr(2'd2, 32'h0F);
      wr(2'd2, 32'h30);
      chk("R10 active or", active_q, 32'h3F);
      @(negedge clk);
      fin_set = 32'h05;
      @(negedge clk);
      fin_set = 32'h0;
      chk("R10 finish alone no change", active_q, 32'h3F);
      act_rd = 1'b1;
      @(negedge clk);
      act_rd = 1'b0;
      chk("R10 read retires finished", active_q, 32'h3A);
      act_rd = 1'b1;
      @(negedge clk);
      act_rd = 1'b0;
      chk("R10 finished set emptied", active_q, 32'h3A);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hang expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      idle(3);
      t_reset();
      rst_n = 1'b1;
      idle(1);
      t_ctrl();
      t_start_gate();
      t_or_and_block();
      t_restart();
      t_busy();
      t_active();
      idle(2);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule